// File: doc/BRIEF.md
# NCO Quadrature Upconversion Mixer

This block shifts a complex baseband stream to a programmable carrier and folds it into a single real sample stream. A 32-bit phase accumulator steps by a frequency tuning word once for every accepted input sample, so the oscillator runs at the sample rate of the data feeding it. A 16-bit static phase offset is added to the accumulated phase. The top bits of that sum address a sine table computed at elaboration, which returns a cosine and a sine value. The cosine multiplies the I sample, the sine (optionally negated) multiplies the Q sample, and the two products are added, rounded and clipped to a 16-bit output.

The block sits between an interpolation chain and a converter. The upstream logic presents one sample per cycle with a valid flag. The tuning word, offset and sine polarity control are plain inputs, sampled together with each sample. A tuning word above half the phase range steps the phase backwards, so it produces the aliased carrier at fclk·(1 − FTW/2^32).

Top module: `nco_mixer`

## Requirements
- R1: The 32-bit phase accumulator resets to 0. Each cycle with `in_valid` high it uses its current value for that sample and then adds `ftw` modulo 2^32. Cycles with `in_valid` low leave it unchanged, whatever `ftw` holds.
- R2: The table index is bits [31:22] of (accumulator + `phase_off`·2^16) modulo 2^32, so `phase_off` lines up with the top 16 phase bits.
- R3: Table entry k (0..1023) is floor(32767·sin(2πk/1024) + 0.5). The sine value is entry k and the cosine value is entry (k+256) mod 1024.
- R4: When `sin_pass` is 1 the sine value is used unchanged. When it is 0, the reset and default level, the negated sine value is used.
- R5: The output value is floor((I·cos + Q·s + 2^14) / 2^15), where s is the sine value selected in R4.
- R6: The R5 result is clipped to the signed 16-bit range [-32768, 32767].
- R7: `out_valid` repeats `in_valid` exactly 4 clock cycles later, and `out_data` carries the result for that sample in the same cycle.
- R8: While `rst_n` is low, `out_valid` and `out_data` go to 0 and the accumulator returns to 0.
- R9: A tuning word of 2^31 or more steps the phase backwards by 2^32 − FTW. For example, 0xC0000000 visits the table indices 0, 768, 512, 256 in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample present this cycle |
| in_i | input | 16 | In-phase sample, signed |
| in_q | input | 16 | Quadrature sample, signed |
| ftw | input | 32 | Frequency tuning word, phase step per sample |
| phase_off | input | 16 | Static phase offset, top 16 phase bits |
| sin_pass | input | 1 | 1 uses the sine as is, 0 uses the negated sine |
| out_valid | output | 1 | Output sample present this cycle |
| out_data | output | 16 | Mixed, rounded and clipped sample, signed |

## Verification
The accumulator properties take `ftw` and `in_valid` to be driven to known levels on every clock edge after reset. The latency property takes `in_valid` to be low during reset. The bench drives every input from the first cycle and holds `in_valid` low whenever `rst_n` is low. In idle cycles it puts unrelated tuning words on the bus, so the hold property has something to check against. The bench resets the block a second time partway through the run, which lets the clipping cases start from a known phase. The pipeline has drained before that reset, so every expected result has already been consumed.

// File: rtl/nco_mixer_pkg.sv
// Package: shared helpers for the NCO mixer.
// Assumes: callers pass a table address width of 16 bits or less.
package nco_mixer_pkg;

    localparam real TWO_PI = 6.283185307179586476925;

    // Rounded sine table entry k of a 2^aw-entry full-wave table with peak amp.
    function automatic int sin_entry(input int k, input int aw, input int amp);
        real x;
        x = real'(amp) * $sin(TWO_PI * real'(k) / real'(1 << aw));
        return $rtoi($floor(x + 0.5));
    endfunction

endpackage

// File: rtl/nco_phase_gen.sv
// Module: phase accumulator plus static offset, one register stage.
// Assumes: PW >= OW and PW >= AW; the accumulator steps only on valid samples.
module nco_phase_gen #(
    parameter int PW = 32,
    parameter int OW = 16,
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [PW-1:0] ftw,
    input  logic [OW-1:0] phase_off,
    output logic [PW-1:0] acc,
    output logic          idx_valid,
    output logic [AW-1:0] idx
);
    localparam int OFF_SHIFT = PW - OW;
    localparam int IDX_SHIFT = PW - AW;

    logic [PW-1:0] phase_sum;

    // Offset the current accumulator value before the table lookup.
    always_comb begin
        phase_sum = acc + (PW'(phase_off) << OFF_SHIFT);
    end

    // Step the accumulator and register the table index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            idx_valid <= 1'b0;
            idx       <= '0;
        end else begin
            idx_valid <= in_valid;
            if (in_valid) begin
                acc <= acc + ftw;
                idx <= AW'(phase_sum >> IDX_SHIFT);
            end
        end
    end
endmodule

// File: rtl/nco_sincos_rom.sv
// Module: full-wave sine table built at elaboration; cosine via quarter shift.
// Assumes: the table peak 2^(DW-1)-1 keeps the negated sine inside DW bits.
module nco_sincos_rom #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [AW-1:0]        idx,
    input  logic                 sin_pass,
    output logic                 out_valid,
    output logic signed [DW-1:0] cos_o,
    output logic signed [DW-1:0] sin_o
);
    localparam int DEPTH = 1 << AW;
    localparam int QTR   = DEPTH / 4;
    localparam int AMP   = (1 << (DW - 1)) - 1;

    logic signed [DW-1:0] tbl_w [DEPTH];
    logic [AW-1:0]        cos_idx;

    for (genvar k = 0; k < DEPTH; k++) begin : g_tbl
        localparam int VAL = nco_mixer_pkg::sin_entry(k, AW, AMP);
        assign tbl_w[k] = DW'(VAL);
    end

    // Cosine address sits a quarter turn ahead of the sine address.
    always_comb begin
        cos_idx = idx + AW'(QTR);
    end

    // Register both lookups and apply the sine polarity choice.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            cos_o     <= '0;
            sin_o     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                cos_o <= tbl_w[cos_idx];
                sin_o <= sin_pass ? tbl_w[idx] : -tbl_w[idx];
            end
        end
    end
endmodule

// File: rtl/nco_mix_sum.sv
// Module: two multipliers, then sum, round half up and clip to DW bits.
// Assumes: inputs are Q(DW-1) fixed point; one stage for products, one for the sum.
module nco_mix_sum #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] data_i,
    input  logic signed [DW-1:0] data_q,
    input  logic signed [DW-1:0] cos_v,
    input  logic signed [DW-1:0] sin_v,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_data
);
    localparam int PRW  = 2 * DW;
    localparam int SW   = PRW + 2;
    localparam int FRAC = DW - 1;
    localparam logic signed [SW-1:0] RND  = SW'(1) <<< (FRAC - 1);
    localparam logic signed [SW-1:0] MAXV = SW'((1 << (DW - 1)) - 1);
    localparam logic signed [SW-1:0] MINV = -MAXV - SW'(1);

    logic                  prod_valid;
    logic signed [PRW-1:0] prod_i;
    logic signed [PRW-1:0] prod_q;
    logic signed [SW-1:0]  sum_w;
    logic signed [SW-1:0]  rnd_w;

    // Register both products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_valid <= 1'b0;
            prod_i     <= '0;
            prod_q     <= '0;
        end else begin
            prod_valid <= in_valid;
            if (in_valid) begin
                prod_i <= data_i * cos_v;
                prod_q <= data_q * sin_v;
            end
        end
    end

    // Add the products and round the sum back to DW-1 fraction bits.
    always_comb begin
        sum_w = SW'(prod_i) + SW'(prod_q);
        rnd_w = (sum_w + RND) >>> FRAC;
    end

    // Clip the rounded sum and register the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= prod_valid;
            if (prod_valid) begin
                if (rnd_w > MAXV)      out_data <= DW'(MAXV);
                else if (rnd_w < MINV) out_data <= DW'(MINV);
                else                   out_data <= DW'(rnd_w);
            end
        end
    end
endmodule

// File: rtl/nco_mixer.sv
// Module: top of the NCO upconversion mixer; four register stages end to end.
// Assumes: one sample per cycle at most; the controls are sampled with each sample.
module nco_mixer #(
    parameter int PW = 32,
    parameter int OW = 16,
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] in_i,
    input  logic signed [DW-1:0] in_q,
    input  logic [PW-1:0]        ftw,
    input  logic [OW-1:0]        phase_off,
    input  logic                 sin_pass,
    output logic                 out_valid,
    output logic signed [DW-1:0] out_data
);
    logic [PW-1:0]        phase_acc;
    logic                 s1_valid;
    logic [AW-1:0]        s1_idx;
    logic signed [DW-1:0] s1_i, s1_q, s2_i, s2_q;
    logic                 s1_pass;
    logic                 s2_valid;
    logic signed [DW-1:0] s2_cos, s2_sin;

    nco_phase_gen #(.PW(PW), .OW(OW), .AW(AW)) u_phase (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ftw(ftw),
        .phase_off(phase_off), .acc(phase_acc),
        .idx_valid(s1_valid), .idx(s1_idx)
    );

    // Carry the data samples and the polarity control alongside the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_i    <= '0;
            s1_q    <= '0;
            s1_pass <= 1'b0;
            s2_i    <= '0;
            s2_q    <= '0;
        end else begin
            if (in_valid) begin
                s1_i    <= in_i;
                s1_q    <= in_q;
                s1_pass <= sin_pass;
            end
            if (s1_valid) begin
                s2_i <= s1_i;
                s2_q <= s1_q;
            end
        end
    end

    nco_sincos_rom #(.AW(AW), .DW(DW)) u_rom (
        .clk(clk), .rst_n(rst_n), .in_valid(s1_valid), .idx(s1_idx),
        .sin_pass(s1_pass), .out_valid(s2_valid), .cos_o(s2_cos), .sin_o(s2_sin)
    );

    nco_mix_sum #(.DW(DW)) u_mix (
        .clk(clk), .rst_n(rst_n), .in_valid(s2_valid),
        .data_i(s2_i), .data_q(s2_q), .cos_v(s2_cos), .sin_v(s2_sin),
        .out_valid(out_valid), .out_data(out_data)
    );
endmodule

// File: rtl/nco_mixer_chk.sv
// Module: property checker for nco_mixer, bound to every instance.
// Assumes: in_valid and ftw are driven to known levels on each edge after reset.
module nco_mixer_chk #(
    parameter int PW = 32,
    parameter int DW = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [PW-1:0]        ftw,
    input logic [PW-1:0]        acc,
    input logic                 out_valid,
    input logic signed [DW-1:0] out_data
);
    logic [2:0] warm_cnt;

    // Count edges since reset so the latency check never looks before it.
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_cnt <= '0;
        else if (warm_cnt != 3'd4) warm_cnt <= warm_cnt + 3'd1;
    end

    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> acc == $past(acc) + $past(ftw)); // R1
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(acc)); // R1
    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_cnt == 3'd4) |-> out_valid == $past(in_valid, 4)); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_data == '0 && acc == '0)); // R8
endmodule

bind nco_mixer nco_mixer_chk #(.PW(PW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ftw(ftw),
    .acc(phase_acc), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/nco_mixer_test.sv
// Scoreboard bench: the driver pushes model results, the monitor pops and compares.
module nco_mixer_test;
    localparam real TWO_PI = 6.283185307179586476925;

    typedef struct {
        int    exp_val;
        string tag;
    } item_t;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_i = '0;
    logic signed [15:0] in_q = '0;
    logic [31:0]        ftw = '0;
    logic [15:0]        phase_off = '0;
    logic               sin_pass = 1'b0;
    logic               out_valid;
    logic signed [15:0] out_data;

    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;
    logic [31:0] bacc = '0;
    item_t       sb[$];

    nco_mixer uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
        .ftw(ftw), .phase_off(phase_off), .sin_pass(sin_pass),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #5 clk = ~clk;

    function automatic int tbl(input int k);
        real x;
        x = 32767.0 * $sin(TWO_PI * real'(k) / 1024.0);
        return $rtoi($floor(x + 0.5));
    endfunction

    function automatic int model(input int i, input int q, input logic [31:0] ph, input bit pass);
        int     k, c, s;
        longint sum, r;
        k = int'(ph[31:22]);
        c = tbl((k + 256) % 1024);
        s = pass ? tbl(k) : -tbl(k);
        sum = longint'(i) * c + longint'(q) * s;
        r = (sum + 16384) >>> 15;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return int'(r);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input int i, input int q, input logic [31:0] f,
                        input logic [15:0] off, input bit pass, input string tag);
        item_t it;
        @(negedge clk);
        in_valid  = 1'b1;
        in_i      = 16'(i);
        in_q      = 16'(q);
        ftw       = f;
        phase_off = off;
        sin_pass  = pass;
        it.exp_val = model(i, q, bacc + {off, 16'h0000}, pass);
        it.tag     = tag;
        sb.push_back(it);
        bacc = bacc + f;
    endtask

    task automatic idle(input int n);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            in_valid = 1'b0;
            ftw      = 32'h1357_9BDF + 32'(c);
            in_i     = 16'(c * 777);
        end
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
    endtask

    // Monitor: compare each produced sample with the oldest expected one.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7 unexpected output", int'(out_data), 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(int'(out_data) == it.exp_val, it.tag, int'(out_data), it.exp_val);
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R8 valid in reset", int'(out_valid), 0);
        check(out_data == 16'sd0, "R8 data in reset", int'(out_data), 0);
        rst_n = 1'b1;
        idle(3);
        check(out_valid == 1'b0, "R8 idle after reset", int'(out_valid), 0);

        // R7: exact latency of one sample, zero phase (R5 directed case).
        send(32767, 1234, 32'h0, 16'h0, 1'b1, "R5 zero phase full I");
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            in_valid = 1'b0;
            check(out_valid == 1'b0, "R7 early valid", int'(out_valid), 0);
        end
        @(negedge clk);
        check(out_valid == 1'b1, "R7 valid at 4 cycles", int'(out_valid), 1);
        check(out_data == 16'sd32766, "R5 directed value", int'(out_data), 32766);
        idle(4);

        send(-20000, 5000, 32'h0, 16'h0, 1'b1, "R5 negative I");
        // R2: quarter turn offset moves the lookup to index 256.
        send(1000, 10000, 32'h0, 16'h4000, 1'b1, "R2 quarter offset");
        // R4: negated sine on the same phase.
        send(1000, 10000, 32'h0, 16'h4000, 1'b0, "R4 negated sine");
        send(-3000, -12000, 32'h0, 16'h2A00, 1'b1, "R2 odd offset");
        idle(5);

        // R1: steady stepping with idle gaps carrying other tuning words.
        for (int n = 0; n < 12; n++) begin
            send(20000 - n * 2500, 8000 + n * 1100, 32'h0100_0000, 16'h0,
                 (n % 2) == 1, "R1 accumulate");
            if (n % 3 == 2) idle(2);
        end
        // R9: backward quarter-turn steps.
        for (int n = 0; n < 4; n++)
            send(32767, 0, 32'hC000_0000, 16'h0, 1'b1, "R9 negative step");
        // R3: single index steps over the table.
        for (int n = 0; n < 40; n++)
            send(32767, 32767, 32'h0040_0000, 16'h0, 1'b1, "R3 table sweep");
        for (int n = 0; n < 20; n++)
            send(-32768 + n * 3000, 15000 - n * 1700, 32'h0723_4567, 16'(n * 911),
                 (n % 3) == 0, "R4 mixed polarity");
        idle(6);
        drain();

        // R8: reset again clears the accumulator; then clipping cases.
        @(negedge clk);
        rst_n = 1'b0;
        bacc  = '0;
        idle(3);
        rst_n = 1'b1;
        send(32767, -32768, 32'h0, 16'h2000, 1'b0, "R6 clip high");
        send(-32768, 32767, 32'h0, 16'h2000, 1'b0, "R6 clip low");
        send(20000, -20000, 32'h0, 16'h2000, 1'b0, "R6 below limit");
        idle(6);
        drain();
        check(model(32767, -32768, 32'h2000_0000, 1'b0) == 32767, "R6 model ceiling",
              model(32767, -32768, 32'h2000_0000, 1'b0), 32767);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule